// File: doc/BRIEF.md
# UART Receive Byte Buffer with Bus Access

This block is the receive side of a simple UART peripheral, seen from the processor. A byte source feeds it: a deserializer or a host-side stream that presents at most one byte per clock and may present several in a row. The block stores the bytes in a 1024-entry buffer. Software pulls them out one at a time by reading a data register over an APB-style 32-bit peripheral bus.

The buffer does not wrap. Bytes are appended at the current fill length, and a separate read index walks up behind them. Space freed by reads is not reused until the read index catches up with the fill length. At that point both indices return to zero. The exact number of free slots is driven back to the byte source as flow control.

A status register reports whether data is waiting and whether a byte was dropped. A 32-bit control register is fully readable and writable, and its bit 0 enables a one-cycle receive interrupt.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset, `freeSlots` equals 1024, `rxIrq` is low, and a status read returns 0.
- R2: Bytes come out of the data register (offset 0x00) in the order they were accepted. The byte sits in bits 7:0 and bits 31:8 read as zero.
- R3: `freeSlots` always equals 1024 minus the fill length. The fill length rises by one for each accepted byte and does not fall when a read leaves unread bytes behind.
- R4: When a read removes the last unread byte, the fill length and the read index both return to zero, so `freeSlots` is back at 1024 in the next cycle.
- R5: A data-register read with no unread byte returns 0 and changes no state.
- R6: Status bit 0 (data ready) is 1 exactly when at least one unread byte is held. It is set by an accepted byte and cleared by a read that leaves no unread byte.
- R7: A read at offset 0x03 behaves like a read at offset 0x00: it returns and removes the same head byte.
- R8: The control register at offset 0x08 stores all 32 written bits and reads them back unchanged. Bit 0 is the receive-interrupt enable.
- R9: `rxIrq` is high for exactly one cycle, in the cycle after the first byte of a burst is accepted, and only if control bit 0 is 1. A burst is a run of consecutive cycles in which a byte is accepted.
- R10: A byte that arrives while the fill length is 1024, and no read is draining the buffer in the same cycle, is dropped and sets status bit 1 (overflow). A status read returns the flag and then clears it.
- R11: The scaler offset 0x0C and all unmapped offsets read as 0. Writes to them have no effect.
- R12: The status register at offset 0x04 is read-only. A write to it changes neither status bit.
- R13: A byte is removed only in the access phase of a read (`psel` and `penable` both high). A setup-phase cycle alone removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte offset within the block |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| inValid | input | 1 | Incoming byte present this cycle |
| inByte | input | 8 | Incoming byte |
| freeSlots | output | 11 | Free buffer entries, 1024 minus the fill length |
| rxIrq | output | 1 | One-cycle receive interrupt pulse |

## Verification
Random bursts of one to eight bytes are interleaved with reads at offsets 0x00 and 0x03, with the interrupt enable toggled at random. This separates the linear fill, where `freeSlots` holds its value while unread bytes remain, from a ring that would give space back on every read. It also separates a burst-start pulse from a per-byte interrupt. Directed cases fill the buffer to 1024 and push one more byte to expose the drop path and the overflow flag. Further directed cases read the empty buffer, hold a setup phase with no access phase, and write to the status, scaler and unmapped offsets. Each is checked against a queue model in the bench.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;

  typedef struct packed {
    logic push;
    logic pop;
  } rxb_strobe_t;

  localparam logic [7:0] OFS_DATA   = 8'h00;
  localparam logic [7:0] OFS_DATA_B = 8'h03;
  localparam logic [7:0] OFS_STAT   = 8'h04;
  localparam logic [7:0] OFS_CTRL   = 8'h08;
  localparam logic [7:0] OFS_SCALE  = 8'h0C;

endpackage

// File: rtl/rxb_datapath.sv
module rxb_datapath
  import uart_rxb_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxb_strobe_t      strobe,
  input  logic [7:0]       inByte,
  output logic             hasData,
  output logic             full,
  output logic             lastByte,
  output logic [7:0]       headByte,
  output logic [IDX_W:0]   freeSlots
);

  localparam logic [IDX_W:0] DEPTH_V = (IDX_W+1)'(DEPTH);

  logic [7:0]     mem [DEPTH];
  logic [IDX_W:0] fillLen;
  logic [IDX_W:0] rdIdx;
  logic [IDX_W:0] wrIdx;
  logic           drain;

  assign hasData   = rdIdx < fillLen;
  assign full      = fillLen == DEPTH_V;
  assign lastByte  = (rdIdx + 1'b1) == fillLen;
  assign headByte  = mem[rdIdx[IDX_W-1:0]];
  assign freeSlots = DEPTH_V - fillLen;
  assign drain     = strobe.pop && lastByte;
  assign wrIdx     = drain ? '0 : fillLen;

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrIdx[IDX_W-1:0]] <= inByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillLen <= '0;
      rdIdx   <= '0;
    end else if (drain) begin
      rdIdx   <= '0;
      fillLen <= strobe.push ? (IDX_W+1)'(1) : '0;
    end else begin
      if (strobe.pop)  rdIdx   <= rdIdx + 1'b1;
      if (strobe.push) fillLen <= fillLen + 1'b1;
    end
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fillLen <= DEPTH_V); // R3
  AST_RD_WITHIN: assert property (@(posedge clk) disable iff (!rstN)
    rdIdx <= fillLen); // R2
  AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop && lastByte && !strobe.push |=> fillLen == 0 && rdIdx == 0); // R4
  AST_POP_ADVANCES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop && !lastByte |=> rdIdx == $past(rdIdx) + 1'b1); // R2

endmodule

// File: rtl/rxb_control.sv
module rxb_control
  import uart_rxb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [7:0]  paddr,
  input  logic [31:0] pwdata,
  input  logic        inValid,
  input  logic        hasData,
  input  logic        full,
  input  logic        lastByte,
  input  logic [7:0]  headByte,
  output rxb_strobe_t strobe,
  output logic [31:0] prdata,
  output logic        rxIrq
);

  logic        rdAccess, wrAccess, dataHit, dropByte;
  logic [31:0] ctrlReg;
  logic        dataReady, ovflFlag, pushPrev, irqQ;
  logic        popDrains, emptyRead;

  assign rdAccess  = psel && penable && !pwrite;
  assign wrAccess  = psel && penable && pwrite;
  assign dataHit   = (paddr == OFS_DATA) || (paddr == OFS_DATA_B);
  assign emptyRead = rdAccess && dataHit && !hasData;

  assign strobe.pop  = rdAccess && dataHit && hasData;
  assign popDrains   = strobe.pop && lastByte;
  assign strobe.push = inValid && (!full || popDrains);
  assign dropByte    = inValid && !strobe.push;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      dataReady <= 1'b0;
      ovflFlag  <= 1'b0;
      pushPrev  <= 1'b0;
      irqQ      <= 1'b0;
    end else begin
      if (wrAccess && paddr == OFS_CTRL) ctrlReg <= pwdata;
      if (strobe.push)                   dataReady <= 1'b1;
      else if (popDrains || emptyRead)   dataReady <= 1'b0;
      if (dropByte)                                  ovflFlag <= 1'b1;
      else if (rdAccess && paddr == OFS_STAT)        ovflFlag <= 1'b0;
      pushPrev <= strobe.push;
      irqQ     <= strobe.push && !pushPrev && ctrlReg[0];
    end
  end

  assign rxIrq = irqQ;

  always_comb begin
    prdata = '0;
    if (rdAccess) begin
      case (paddr)
        OFS_DATA, OFS_DATA_B: prdata = hasData ? {24'h0, headByte} : '0;
        OFS_STAT:             prdata = {30'h0, ovflFlag, dataReady};
        OFS_CTRL:             prdata = ctrlReg;
        OFS_SCALE:            prdata = '0;
        default:              prdata = '0;
      endcase
    end
  end

  AST_READY_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    dataReady == hasData); // R6
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |=> !rxIrq); // R9
  AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push && !ctrlReg[0] |=> !rxIrq); // R9
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    dropByte |=> ovflFlag); // R10
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    emptyRead |-> prdata == 32'h0); // R5

endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import uart_rxb_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [7:0]       paddr,
  input  logic [31:0]      pwdata,
  output logic [31:0]      prdata,
  input  logic             inValid,
  input  logic [7:0]       inByte,
  output logic [IDX_W:0]   freeSlots,
  output logic             rxIrq
);

  rxb_strobe_t strobe;
  logic        hasData, full, lastByte;
  logic [7:0]  headByte;

  rxb_control u_ctrl (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .inValid(inValid), .hasData(hasData),
    .full(full), .lastByte(lastByte), .headByte(headByte), .strobe(strobe),
    .prdata(prdata), .rxIrq(rxIrq)
  );

  rxb_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inByte(inByte),
    .hasData(hasData), .full(full), .lastByte(lastByte),
    .headByte(headByte), .freeSlots(freeSlots)
  );

endmodule

// File: tb/sim_uart_rx_buffer.sv
module sim_uart_rx_buffer;

  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        inValid = 1'b0;
  logic [7:0]  inByte = '0;
  logic [10:0] freeSlots;
  logic        rxIrq;

  int total = 0, bad = 0;
  logic [7:0] q[$];
  int modelLen = 0;
  bit modelOvf = 0;
  bit irqEn = 0;

  always #2 clk = ~clk;

  uart_rx_buffer u0 (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .inValid(inValid),
    .inByte(inByte), .freeSlots(freeSlots), .rxIrq(rxIrq)
  );

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic int expFree();
    return DEPTH - modelLen;
  endfunction

  function automatic logic [31:0] expStatus();
    return {30'h0, modelOvf, (q.size() != 0)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apbRead(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic apbWrite(logic [7:0] a, logic [31:0] v);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = v;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic modelPush(logic [7:0] b);
    if (modelLen < DEPTH) begin q.push_back(b); modelLen++; end
    else modelOvf = 1;
  endtask

  task automatic readData(logic [7:0] a, string req);
    logic [31:0] d;
    logic [31:0] exp;
    exp = 0;
    apbRead(a, d);
    if (q.size() != 0) begin
      exp = {24'h0, q.pop_front()};
      if (q.size() == 0) modelLen = 0;
    end
    check(req, d, exp);
    #1 check("R3 free after read", 32'(freeSlots), 32'(expFree()));
  endtask

  task automatic pushBurst(int n, bit checkIrq);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1; inByte = 8'($urandom);
      modelPush(inByte);
      if (i > 0 && checkIrq) begin
        #1 check("R9 irq in burst", 32'(rxIrq), 32'(i == 1 && irqEn));
      end
    end
    @(negedge clk); inValid = 0;
    if (checkIrq) begin
      #1 check("R9 irq after burst", 32'(rxIrq), 32'(n == 1 && irqEn));
    end
    #1 check("R3 free after burst", 32'(freeSlots), 32'(expFree()));
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    #1 check("R1 free at reset", 32'(freeSlots), 32'(DEPTH));
    check("R1 irq at reset", 32'(rxIrq), 0);
    apbRead(8'h04, d); check("R1 status at reset", d, 0);

    readData(8'h00, "R5 empty read");
    apbRead(8'h04, d); check("R5 status after empty read", d, 0);

    apbWrite(8'h08, 32'hA5C3_7E01); irqEn = 1;
    apbRead(8'h08, d); check("R8 control readback", d, 32'hA5C3_7E01);

    pushBurst(3, 1);
    apbRead(8'h04, d); check("R6 ready set", d, expStatus());
    readData(8'h00, "R2 first byte");
    readData(8'h03, "R7 byte-lane offset");
    #1 check("R3 no space reuse", 32'(freeSlots), 32'(DEPTH - 3));
    readData(8'h00, "R4 last byte");
    #1 check("R4 drained", 32'(freeSlots), 32'(DEPTH));
    apbRead(8'h04, d); check("R6 ready cleared", d, 0);

    pushBurst(2, 1);
    @(negedge clk); psel = 1; penable = 0; paddr = 8'h00; pwrite = 0;
    @(negedge clk); @(negedge clk); psel = 0;
    #1 check("R13 setup phase only", 32'(freeSlots), 32'(expFree()));
    readData(8'h00, "R13 head kept");

    apbWrite(8'h04, 32'h0);
    apbRead(8'h04, d); check("R12 status read-only", d, expStatus());
    apbWrite(8'h0C, 32'hFFFF_FFFF);
    apbRead(8'h0C, d); check("R11 scaler zero", d, 0);
    apbRead(8'h20, d); check("R11 unmapped zero", d, 0);
    apbRead(8'h08, d); check("R11 control untouched", d, 32'hA5C3_7E01);

    for (int it = 0; it < 300; it++) begin
      int op;
      op = $urandom_range(0, 3);
      if (op == 0) begin
        irqEn = $urandom_range(0, 1);
        apbWrite(8'h08, {31'h0, irqEn});
      end else if (op == 1 && modelLen <= DEPTH - 8) begin
        pushBurst($urandom_range(1, 8), 1);
      end else begin
        readData($urandom_range(0, 1) ? 8'h00 : 8'h03, "R2 random read");
      end
    end
    while (q.size() != 0) readData(8'h00, "R2 drain");
    #1 check("R4 drained after random", 32'(freeSlots), 32'(DEPTH));

    pushBurst(DEPTH, 0);
    #1 check("R3 full", 32'(freeSlots), 0);
    pushBurst(1, 0);
    apbRead(8'h04, d); check("R10 overflow flag", d, expStatus());
    modelOvf = 0;
    apbRead(8'h04, d); check("R10 flag cleared", d, expStatus());
    while (q.size() != 0) readData(8'h00, "R10 drop kept data");
    #1 check("R4 final drain", 32'(freeSlots), 32'(DEPTH));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule